// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block produces the next program counter for a processor that can repeat a short run of instructions without spending any branch cycles. Each cycle it receives the instruction word being executed, that instruction's address and a step strobe. It returns the address to fetch next and the number of cycles the instruction takes. When the strobe is high, the block also updates its own loop state: the first body address, the address just past the body, the remaining pass count, the resume address and the active flag.

A loop instruction comes in two forms, and the two share one opcode. The capture form sets up a new block of one to fifteen instructions that starts right after the loop instruction. The replay form runs the last captured block again and then continues at the address after the replay instruction. Every other instruction advances the address by one, except when a loop is running and the next address would step past the body. In that case the address returns to the body start, or leaves the loop after the final pass.

Top module: `loop_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `loop_active` is 0 and no block is captured. A replay issued in this state gives `next_pc = pc+1` and `cycles = 1`.
- R2: A loop word has bits 15:11 = 5'h0E. A nonzero body length NI in bits 10:7 makes it a capture. A capture gives `next_pc = pc+1` and `cycles = 1`, sets `loop_active`, and records the body as addresses pc+1 through pc+NI.
- R3: A loop word with NI = 0 is a replay. When a block has been captured, it gives `next_pc` equal to the captured body start and `cycles = 2`, and it sets `loop_active`.
- R4: While a loop is active and passes remain, a non-loop instruction at the last body address (so pc+1 equals the body end) gives `next_pc` equal to the body start.
- R5: The pass count K in bits 6:0 sets the number of body passes: K passes for K ≥ 1, and one pass for K = 0.
- R6: At the end of the final pass of a captured loop, `next_pc = pc+1` (fall-through) and `loop_active` clears.
- R7: At the end of the final pass of a replayed loop, `next_pc` equals the replay instruction's address plus one, `loop_active` clears, and the resume address returns to the invalid value 16'hFFFF.
- R8: A non-loop instruction while no loop is active gives `next_pc = pc+1` and `cycles = 1`. A cycle with `step_en` low changes no loop state, so a stalled end-of-body cycle does not use up a pass.
- R9: A word whose bits 15:11 differ from 5'h0E is never treated as a loop instruction, whatever its low bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | The current instruction completes this cycle; loop state may update |
| instr | input | 16 | Instruction word being executed |
| pc | input | 16 | Address of that instruction |
| next_pc | output | 16 | Address to fetch next |
| cycles | output | 2 | Cycle count of the current instruction (1 or 2) |
| loop_active | output | 1 | A loop body is being repeated |

## Verification
The critical overlap is the final end-of-body arrival of a replayed loop. In that one cycle the last-pass exit and the reload of the resume address both happen, and the sequencer must choose the resume address over both the wrap back to the body start and the plain fall-through. The bench causes this for every capture length and pass count it sweeps: it captures a block, finishes it, issues a replay somewhere else, and checks that the last body address leads to the replay address plus one with `loop_active` dropping. A stalled cycle at the first end arrival, with the strobe low, checks separately that the wrap decision and the counter update stay tied to the strobe.

// File: rtl/loop_seq_pkg.sv
// Package: shared constants for the loop sequencer.
// Assumes a 16-bit instruction word with the loop opcode in the top five bits.
package loop_seq_pkg;
    localparam int unsigned OPC_W    = 5;
    localparam int unsigned NI_W     = 4;
    localparam int unsigned K_W      = 7;
    localparam int unsigned INSTR_W  = OPC_W + NI_W + K_W;
    localparam logic [OPC_W-1:0] LOOP_OPC = 5'h0E;
endpackage

// File: rtl/loop_decode.sv
// Module: loop_decode
// Splits an instruction word into its loop-form flags and fields.
// Assumes the opcode is in the top bits, then the body length, then the pass count.
module loop_decode
    import loop_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_capture,
    output logic               is_replay,
    output logic [NI_W-1:0]    body_len,
    output logic [K_W-1:0]     pass_cnt
);
    logic [OPC_W-1:0] opc;

    // Field extraction and form selection
    always_comb begin
        opc        = instr[INSTR_W-1 -: OPC_W];
        body_len   = instr[K_W +: NI_W];
        pass_cnt   = instr[K_W-1:0];
        is_capture = (opc == LOOP_OPC) && (body_len != '0);
        is_replay  = (opc == LOOP_OPC) && (body_len == '0);
    end
endmodule

// File: rtl/loop_ctrl.sv
// Module: loop_ctrl
// Combinational next-address selection and action strobes for the loop sequencer.
// Assumes no loop nesting: loop words inside a body are not checked for the body end.
module loop_ctrl #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 7
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              is_capture,
    input  logic              is_replay,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ADDR_W-1:0] resume_q,
    input  logic              active_q,
    output logic [ADDR_W-1:0] next_pc,
    output logic [1:0]        cycles,
    output logic              act_capture,
    output logic              act_replay,
    output logic              act_wrap,
    output logic              act_done
);
    localparam logic [ADDR_W-1:0] INV = '1;

    logic [ADDR_W-1:0] lin_pc;
    logic              at_end;

    // Decide the action for this instruction
    always_comb begin
        lin_pc      = pc + ADDR_W'(1);
        act_capture = is_capture;
        act_replay  = is_replay && (start_q != INV);
        at_end      = active_q && !is_capture && !is_replay && (lin_pc == end_q);
        act_wrap    = at_end && (cnt_q != '0);
        act_done    = at_end && (cnt_q == '0);
    end

    // Select the next fetch address and the cycle count
    always_comb begin
        if (act_replay || act_wrap)
            next_pc = start_q;
        else if (act_done && (resume_q != INV))
            next_pc = resume_q;
        else
            next_pc = lin_pc;
        cycles = act_replay ? 2'd2 : 2'd1;
    end
endmodule

// File: rtl/loop_regs.sv
// Module: loop_regs
// Holds the captured body bounds, the remaining pass count, the resume address and the active flag.
// Assumes at most one action strobe is high per cycle; updates only when step_en is high.
module loop_regs #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NI_W   = 4,
    parameter int unsigned CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] pc,
    input  logic [NI_W-1:0]   body_len,
    input  logic [CNT_W-1:0]  pass_cnt,
    input  logic              act_capture,
    input  logic              act_replay,
    input  logic              act_wrap,
    input  logic              act_done,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] resume_q,
    output logic              active_q
);
    localparam logic [ADDR_W-1:0] INV = '1;

    logic [CNT_W-1:0] cnt_load;

    // Remaining wraps: K-1, with K=0 treated as a single pass
    always_comb cnt_load = (pass_cnt == '0) ? '0 : pass_cnt - CNT_W'(1);

    // Loop state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= INV;
            end_q    <= INV;
            cnt_q    <= '0;
            resume_q <= INV;
            active_q <= 1'b0;
        end else if (step_en) begin
            if (act_capture) begin
                start_q  <= pc + ADDR_W'(1);
                end_q    <= pc + ADDR_W'(body_len) + ADDR_W'(1);
                cnt_q    <= cnt_load;
                resume_q <= INV;
                active_q <= 1'b1;
            end else if (act_replay) begin
                cnt_q    <= cnt_load;
                resume_q <= pc + ADDR_W'(1);
                active_q <= 1'b1;
            end else if (act_wrap) begin
                cnt_q    <= cnt_q - CNT_W'(1);
            end else if (act_done) begin
                resume_q <= INV;
                active_q <= 1'b0;
            end
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!active_q && cnt_q == '0 && start_q == INV && resume_q == INV));

    p_capture_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && act_capture) |=> (start_q == $past(pc) + ADDR_W'(1) && active_q));

    p_wrap_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && act_wrap) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && act_done) |=> (!active_q && resume_q == INV));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(cnt_q) && $stable(active_q) && $stable(start_q)));
endmodule

// File: rtl/loop_sequencer.sv
// Module: loop_sequencer
// Next-address sequencer for a zero-overhead loop instruction with capture and replay forms.
// Assumes step_en marks completion of the instruction on instr/pc; loops do not nest.
module loop_sequencer
    import loop_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [1:0]         cycles,
    output logic               loop_active
);
    localparam logic [ADDR_W-1:0] INV = '1;

    logic              is_capture, is_replay;
    logic [NI_W-1:0]   body_len;
    logic [K_W-1:0]    pass_cnt;
    logic [ADDR_W-1:0] start_q, end_q, resume_q;
    logic [K_W-1:0]    cnt_q;
    logic              active_q;
    logic              act_capture, act_replay, act_wrap, act_done;

    loop_decode u_decode (
        .instr      (instr),
        .is_capture (is_capture),
        .is_replay  (is_replay),
        .body_len   (body_len),
        .pass_cnt   (pass_cnt)
    );

    loop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(K_W)) u_ctrl (
        .pc          (pc),
        .is_capture  (is_capture),
        .is_replay   (is_replay),
        .start_q     (start_q),
        .end_q       (end_q),
        .cnt_q       (cnt_q),
        .resume_q    (resume_q),
        .active_q    (active_q),
        .next_pc     (next_pc),
        .cycles      (cycles),
        .act_capture (act_capture),
        .act_replay  (act_replay),
        .act_wrap    (act_wrap),
        .act_done    (act_done)
    );

    loop_regs #(.ADDR_W(ADDR_W), .NI_W(NI_W), .CNT_W(K_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .pc          (pc),
        .body_len    (body_len),
        .pass_cnt    (pass_cnt),
        .act_capture (act_capture),
        .act_replay  (act_replay),
        .act_wrap    (act_wrap),
        .act_done    (act_done),
        .start_q     (start_q),
        .end_q       (end_q),
        .cnt_q       (cnt_q),
        .resume_q    (resume_q),
        .active_q    (active_q)
    );

    // Status output
    always_comb loop_active = active_q;

    p_replay_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_replay && start_q != INV) |-> (next_pc == start_q && cycles == 2'd2));

    p_idle_linear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !(is_replay && start_q != INV)) |-> (next_pc == pc + ADDR_W'(1)));

    p_single_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_capture, act_replay, act_wrap, act_done}));
endmodule

// File: tb/loop_sequencer_bench.sv
// Bench: sweeps every body length and a range of pass counts through capture and replay.
module loop_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [15:0] pc = 16'h0000;
    logic [15:0] next_pc;
    logic [1:0]  cycles;
    logic        loop_active;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    loop_sequencer u_loop_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .instr       (instr),
        .pc          (pc),
        .next_pc     (next_pc),
        .cycles      (cycles),
        .loop_active (loop_active)
    );

    function automatic logic [15:0] loop_word(input int ni, input int k);
        return {5'h0E, 4'(ni), 7'(k)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one instruction, check the combinational outputs, then clock it
    task automatic run_step(input logic [15:0] w, input logic [15:0] a, input logic en,
                            input logic [15:0] exp_pc, input int exp_cyc, input string req);
        @(negedge clk);
        instr = w; pc = a; step_en = en;
        #2;
        check({req, " next_pc"}, int'(next_pc), int'(exp_pc));
        check({req, " cycles"}, int'(cycles), exp_cyc);
        @(posedge clk);
    endtask

    task automatic check_active(input string req, input logic exp);
        @(negedge clk);
        step_en = 1'b0;
        #1;
        check({req, " loop_active"}, int'(loop_active), int'(exp));
    endtask

    // Run the body of a loop that starts at base+1 and has ni instructions
    task automatic run_body(input logic [15:0] base, input int ni, input int passes,
                            input logic [15:0] exit_pc, input string exit_req);
        for (int p = 0; p < passes; p++) begin
            for (int i = 1; i <= ni; i++) begin
                logic [15:0] a;
                logic [15:0] e;
                a = base + 16'(i);
                if (i < ni) e = a + 16'd1;
                else if (p < passes - 1) e = base + 16'd1;
                else e = exit_pc;
                if (i == ni && p == 0)
                    run_step(16'h3000, a, 1'b0, e, 1, "R8 stall");
                run_step(16'h3000, a, 1'b1, e, 1,
                         (i == ni && p < passes - 1) ? "R4 wrap" :
                         (i == ni) ? exit_req : "R5 body");
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_active("R1 reset", 1'b0);
        // R1: replay with nothing captured does not jump
        run_step(loop_word(0, 3), 16'h0040, 1'b1, 16'h0041, 1, "R1 empty replay");
        check_active("R1 empty replay", 1'b0);
        // R8: plain instruction while idle
        run_step(16'h1234, 16'h0050, 1'b1, 16'h0051, 1, "R8 idle");
        // R9: other opcodes with loop-like low bits
        for (int op = 0; op < 32; op++) begin
            if (op != 14) begin
                run_step({5'(op), 4'h3, 7'h02}, 16'h0300, 1'b1, 16'h0301, 1, "R9 other opcode");
                check_active("R9 other opcode", 1'b0);
            end
        end
        // Sweep capture then replay for every body length
        for (int ni = 1; ni < 16; ni++) begin
            for (int k = 0; k < 5; k++) begin
                logic [15:0] base;
                logic [15:0] rp;
                int passes;
                int k2;
                int passes2;
                base = 16'h0200 + 16'(ni * 32);
                rp   = 16'h0800 + 16'(k * 4);
                passes = (k == 0) ? 1 : k;
                k2 = (k + 2) % 5;
                passes2 = (k2 == 0) ? 1 : k2;
                run_step(loop_word(ni, k), base, 1'b1, base + 16'd1, 1, "R2 capture");
                check_active("R2 capture", 1'b1);
                run_body(base, ni, passes, base + 16'(ni) + 16'd1, "R6 fall-through");
                check_active("R6 exit", 1'b0);
                run_step(loop_word(0, k2), rp, 1'b1, base + 16'd1, 2, "R3 replay");
                check_active("R3 replay", 1'b1);
                run_body(base, ni, passes2, rp + 16'd1, "R7 resume");
                check_active("R7 exit", 1'b0);
                // R7: after the resume, the body end address no longer redirects
                run_step(16'h3000, base + 16'(ni), 1'b1, base + 16'(ni) + 16'd1, 1, "R7 cleared");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule